// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital half of a 12-bit successive-approximation converter. A one-cycle start request, accepted only while the block is idle, raises a busy flag and sets the most significant trial bit on the code that feeds an external DAC. On each following clock edge the block judges the current trial bit using one comparator input. It keeps the bit when the DAC value does not exceed the sampled input and clears it otherwise. It then moves the trial to the next lower bit.

A two-bit length select, captured when the request is accepted, stops the walk after 12, 10 or 8 decisions. The outcome is written to an output register in negative-true complementary form, and bits that were never resolved read as ones. The data settles one edge before the busy flag falls, so a consumer can latch it on that falling edge. A second copy of the most significant bit, inverted relative to the data bus, turns the unipolar or offset reading into a twos-complement reading.

Top module: `sar_seq_top`

## Requirements
- R1: After reset, `busy` is 0, `dac_code` is all zeros and `dout_n` is all ones.
- R2: A `start` pulse seen at a rising edge while `busy` is 0 sets `busy` to 1 and `dac_code` to 12'h800 (only the top trial bit) at that edge.
- R3: A `start` pulse while `busy` is 1 has no effect: the result and the busy length stay those of the running conversion.
- R4: Each decision keeps the current trial bit when `cmp_hi` is 0 and clears it when `cmp_hi` is 1, then sets the next lower bit. With an ideal comparator (`cmp_hi` = `dac_code` greater than the input code), the true result equals the input code with its unresolved low bits cleared.
- R5: `busy` stays high for exactly L+1 clock cycles, where L is the selected length: 13, 11 or 9 cycles.
- R6: `dout_n` changes only at the edge of the final decision. That edge comes one cycle before `busy` falls, and between conversions the register holds the previous result.
- R7: `trunc_sel` encoding is 2'b00 for 12 bits, 2'b01 for 10, 2'b10 for 8 and 2'b11 for 12. It is sampled when a conversion starts, and later changes have no effect on the running conversion.
- R8: Unresolved low bits (the lowest 12-L) read as 1 on `dout_n`.
- R9: `msb_inv` is the complement of `dout_n[11]`, giving complementary twos-complement readout when it replaces bit 11.
- R10: Code extremes: input 1 reads 12'hFFE, input 2048 reads 12'h7FF, and input 4095 reads 12'h000 at full length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Conversion request |
| trunc_sel | input | 2 | Conversion length select |
| cmp_hi | input | 1 | Comparator: DAC value above the input |
| busy | output | 1 | Conversion in progress |
| dac_code | output | 12 | Trial code for the DAC |
| dout_n | output | 12 | Result, negative-true complementary |
| msb_inv | output | 1 | Inverted copy of the result MSB |

## Verification
The final bit decision and the write of the output register fall in the same cycle. On the next edge, the busy flag falls while the register must stay put. The bench samples `dout_n` on every cycle that `busy` is high. The value must equal the previous result on all cycles but the last, and the new expected code on the last. Some conversions also get a stray start pulse and a length change part-way through, to show that the in-flight length and result are not disturbed.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
   typedef enum logic [1:0] {
      LEN_FULL  = 2'b00,
      LEN_MID   = 2'b01,
      LEN_SHORT = 2'b10,
      LEN_FULL2 = 2'b11
   } len_sel_e;

   function automatic int sel_to_len(input logic [1:0] sel, input int full,
                                     input int mid, input int short_len);
      case (len_sel_e'(sel))
         LEN_MID:   return mid;
         LEN_SHORT: return short_len;
         default:   return full;
      endcase
   endfunction
endpackage

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
   import sar_seq_pkg::*;
#(
   parameter int NBITS     = 12,
   parameter int LEN_MID   = 10,
   parameter int LEN_SHORT = 8,
   localparam int LW = $clog2(NBITS + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [1:0]    trunc_sel,
   output logic          busy,
   output logic          load,
   output logic          dec_en,
   output logic          last_dec,
   output logic [LW-1:0] len_q
);
   logic          busy_q, fin_q;
   logic [LW-1:0] cnt_q;

   assign busy     = busy_q;
   assign load     = start & ~busy_q;
   assign dec_en   = busy_q & ~fin_q;
   assign last_dec = dec_en && (cnt_q == LW'(len_q - LW'(1)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         fin_q  <= 1'b0;
         cnt_q  <= '0;
         len_q  <= LW'(NBITS);
      end else if (load) begin
         busy_q <= 1'b1;
         fin_q  <= 1'b0;
         cnt_q  <= '0;
         len_q  <= LW'(sel_to_len(trunc_sel, NBITS, LEN_MID, LEN_SHORT));
      end else if (last_dec) begin
         fin_q  <= 1'b1;
      end else if (dec_en) begin
         cnt_q  <= cnt_q + LW'(1);
      end else if (fin_q) begin
         busy_q <= 1'b0;
         fin_q  <= 1'b0;
      end
   end

   // R7
   len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !load) |=> $stable(len_q));
   // R3
   start_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !fin_q) |=> busy_q);
   // R5
   fin_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fin_q |=> !busy_q);
endmodule

// File: rtl/sar_seq_shreg.sv
module sar_seq_shreg #(
   parameter int NBITS = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             dec_en,
   input  logic             last_dec,
   input  logic             cmp_hi,
   output logic [NBITS-1:0] code,
   output logic [NBITS-1:0] decided
);
   localparam logic [NBITS-1:0] TOP = {1'b1, {(NBITS-1){1'b0}}};

   logic [NBITS-1:0] code_q, ptr_q;

   assign code    = code_q;
   assign decided = code_q & ~(cmp_hi ? ptr_q : '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q <= '0;
         ptr_q  <= '0;
      end else if (load) begin
         code_q <= TOP;
         ptr_q  <= TOP;
      end else if (dec_en) begin
         code_q <= decided | (last_dec ? '0 : (ptr_q >> 1));
         ptr_q  <= ptr_q >> 1;
      end
   end

   // R2
   load_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (code_q == TOP));
   // R4
   ptr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ptr_q));
   // R4
   clear_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_en && cmp_hi) |=> ((code_q & $past(ptr_q)) == '0));
endmodule

// File: rtl/sar_seq_outreg.sv
module sar_seq_outreg #(
   parameter int NBITS = 12,
   localparam int LW = $clog2(NBITS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             last_dec,
   input  logic [LW-1:0]    len_q,
   input  logic [NBITS-1:0] decided,
   output logic [NBITS-1:0] res_n
);
   logic [NBITS-1:0] keep;

   for (genvar g = 0; g < NBITS; g++) begin : g_mask
      assign keep[g] = (int'(len_q) + g >= NBITS);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        res_n <= '1;
      else if (last_dec) res_n <= ~(decided & keep);
   end

   // R6
   res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !last_dec |=> $stable(res_n));
   // R8
   low_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
      last_dec |=> (&(res_n | $past(keep))));
endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top #(
   parameter int NBITS     = 12,
   parameter int LEN_MID   = 10,
   parameter int LEN_SHORT = 8,
   localparam int LW = $clog2(NBITS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [1:0]       trunc_sel,
   input  logic             cmp_hi,
   output logic             busy,
   output logic [NBITS-1:0] dac_code,
   output logic [NBITS-1:0] dout_n,
   output logic             msb_inv
);
   if (NBITS < 2) begin : g_bad_width
      $error("NBITS must be at least 2");
   end
   if (LEN_SHORT < 1 || LEN_SHORT > LEN_MID || LEN_MID > NBITS) begin : g_bad_len
      $error("lengths must satisfy 1 <= LEN_SHORT <= LEN_MID <= NBITS");
   end

   logic             load, dec_en, last_dec;
   logic [LW-1:0]    len_q;
   logic [NBITS-1:0] decided;

   sar_seq_ctrl #(.NBITS(NBITS), .LEN_MID(LEN_MID), .LEN_SHORT(LEN_SHORT)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .trunc_sel(trunc_sel),
      .busy(busy), .load(load), .dec_en(dec_en), .last_dec(last_dec), .len_q(len_q)
   );

   sar_seq_shreg #(.NBITS(NBITS)) u_shreg (
      .clk(clk), .rst_n(rst_n), .load(load), .dec_en(dec_en), .last_dec(last_dec),
      .cmp_hi(cmp_hi), .code(dac_code), .decided(decided)
   );

   sar_seq_outreg #(.NBITS(NBITS)) u_out (
      .clk(clk), .rst_n(rst_n), .last_dec(last_dec), .len_q(len_q),
      .decided(decided), .res_n(dout_n)
   );

   assign msb_inv = ~dout_n[NBITS-1];

   // R6
   busy_fall_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $stable(dout_n));
endmodule

// File: tb/sar_seq_top_tb.sv
module sar_seq_top_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  trunc_sel = 2'b00;
   logic        cmp_hi;
   logic        busy, msb_inv;
   logic [11:0] dac_code, dout_n;
   logic [11:0] vin = '0;
   int          errors = 0;
   int          checks = 0;
   logic [11:0] prev_res = 12'hFFF;

   always #5 clk = ~clk;

   assign cmp_hi = (dac_code > vin);

   sar_seq_top u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .trunc_sel(trunc_sel),
      .cmp_hi(cmp_hi), .busy(busy), .dac_code(dac_code), .dout_n(dout_n),
      .msb_inv(msb_inv)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int len_of(input logic [1:0] s);
      return (s == 2'b01) ? 10 : (s == 2'b10) ? 8 : 12;
   endfunction

   task automatic convert(input logic [11:0] v, input logic [1:0] s, input bit disturb);
      int          len, cyc;
      logic [11:0] exp_res, last_seen;
      bit          hold_ok;
      len = len_of(s);
      exp_res = ~(v & (12'hFFF << (12 - len)));
      @(negedge clk);
      vin = v; trunc_sel = s; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      // R2: busy up and top trial bit after the accepting edge
      chk(busy === 1'b1, "R2 busy", int'(busy), 1);
      chk(dac_code === 12'h800, "R2 dac", int'(dac_code), 12'h800);
      cyc = 1; hold_ok = 1'b1; last_seen = dout_n;
      forever begin
         if (disturb && cyc == 4) begin start = 1'b1; trunc_sel = ~s; end  // R3 R7
         if (disturb && cyc == 5) start = 1'b0;
         @(negedge clk);
         if (!busy) break;
         if (last_seen !== prev_res) hold_ok = 1'b0;
         last_seen = dout_n;
         cyc++;
         if (cyc > 20) break;
      end
      start = 1'b0;
      // R5: busy length L+1
      chk(cyc == len + 1, "R5 busy length", cyc, len + 1);
      // R6: held previous value until final decision cycle
      chk(hold_ok, "R6 hold", int'(last_seen), int'(prev_res));
      // R4 R8: final code, unresolved bits as ones, ready before busy falls
      chk(last_seen === exp_res, disturb ? "R3 R7 result" : "R4 R8 result",
          int'(last_seen), int'(exp_res));
      chk(dout_n === exp_res, "R6 after fall", int'(dout_n), int'(exp_res));
      // R9
      chk(msb_inv === ~exp_res[11], "R9 msb_inv", int'(msb_inv), int'(~exp_res[11]));
      prev_res = exp_res;
   endtask

   initial begin
      #1000000;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1
      chk(busy === 1'b0, "R1 busy", int'(busy), 0);
      chk(dac_code === 12'h000, "R1 dac", int'(dac_code), 0);
      chk(dout_n === 12'hFFF, "R1 dout", int'(dout_n), 12'hFFF);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 code extremes
      convert(12'd1, 2'b00, 1'b0);
      chk(dout_n === 12'hFFE, "R10 low", int'(dout_n), 12'hFFE);
      convert(12'd2048, 2'b00, 1'b0);
      chk(dout_n === 12'h7FF, "R10 mid", int'(dout_n), 12'h7FF);
      convert(12'd4095, 2'b00, 1'b0);
      chk(dout_n === 12'h000, "R10 top", int'(dout_n), 12'h000);
      // R7: every select encoding including 2'b11
      for (int s = 0; s < 4; s++) begin
         for (int v = 0; v < 4096; v += 13) convert(12'(v), 2'(s), 1'b0);
         convert(12'hFFF, 2'(s), 1'b0);
         convert(12'h000, 2'(s), 1'b0);
      end
      // R3 R7: stray start and select change mid-conversion
      for (int s = 0; s < 3; s++) begin
         convert(12'hA5C, 2'(s), 1'b1);
         convert(12'h3F1, 2'(s), 1'b1);
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule